// File: doc/BRIEF.md
# Multiplexed Host Port

This block is a slave port through which an external host processor reads and writes the chip's internal memory space. The host is always the master. Its strobes are asynchronous to the internal clock. Address and data travel on the same host bus. The host first loads a word address into an address register. It then moves data through a data register, and each data access becomes one single-beat request on the internal memory port. A control register holds two doorbell flags, one from the host to the local CPU and one back. Both the host and the CPU can see this register.

The host bus is either 32 or 16 bits wide. A strap input sets the width: it is sampled while reset is held and is frozen after that. In the narrow mode a 32-bit word moves as two halfwords on the low bus pins, and a halfword-select input says which half is being transferred. The port pulls its ready output low while an internal access is outstanding. The host must not release its strobe while ready is low. Ready is valid from the fourth clock after the strobe assertion.

Register select encoding on `hostRegSel`:
- `00` control register.
- `01` address register.
- `10` data register, with the address incremented by one word after the internal access completes.
- `11` data register, with the address left unchanged.

Control register layout, the same for host and CPU reads:
- Bit 0: the latched width strap (1 = 32-bit).
- Bit 1: the host-to-CPU flag.
- Bit 2: the CPU-to-host flag.
- All other bits read zero.

Top module: `host_mux_port`

## Requirements
- R1: While reset is held and right after it, `hostReady`=1, `hostIntN`=1, `cpuInt`=0 and `memReq`=0.
- R2: `widthStrap` is sampled only while `rstN`=0 and is reported in control bit 0. Changing the strap after reset has no effect on the mode or on bit 0.
- R3: A host write with select `01` loads the address register from the bus. A host read with select `01` returns the address register, and a host read with select `00` returns the control layout above. Neither access drops ready or starts an internal access.
- R4: In 32-bit mode, each host write with select `1x` stores the bus word in the data register and issues exactly one internal write (`memWe`=1) of that word to the stored address.
- R5: Ready stays low from an accepted data access until the cycle after `memAck`. While `memReq` waits for `memAck`, it stays high and `memAddr` and `memWdata` stay stable.
- R6: A host read with select `1x` (32-bit mode) issues one internal read. The returned `memRdata` word is presented on `hostBusOut` once ready rises again.
- R7: Select `10` increments the stored address by one after the internal access completes. Select `11` leaves the address unchanged.
- R8: In 16-bit mode, writes of address or data with `hostHalf`=0 load the low half from bus bits 15:0 and `hostHalf`=1 loads the high half. Only the high-half data write starts the internal write, which carries the assembled 32-bit word.
- R9: In 16-bit mode, a data read with `hostHalf`=0 starts the internal read and returns the low half. `hostHalf`=1 returns the high half of the same word with no internal access. Bus bits 31:16 read zero in this mode.
- R10: A host control write with bit 1 set raises `cpuInt` (control bit 1). A CPU write with `cpuCtlWdata[0]`=1 clears it, and a set in the same cycle wins.
- R11: A CPU write with `cpuCtlWdata[1]`=1 sets control bit 2 and drives `hostIntN` low. A host control write with bit 2 set clears it, and the CPU set wins a tie.
- R12: Strobes pass through a two-flop synchronizer. One strobe assertion, however long, causes at most one register update and one internal access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low reset |
| widthStrap | input | 1 | Bus width strap, 1 = 32-bit, sampled in reset |
| hostBusIn | input | DW | Multiplexed host bus, host to port |
| hostBusOut | output | DW | Multiplexed host bus, port to host |
| hostBusOe | output | 1 | Port drives the host bus (host read active) |
| hostSelN | input | 1 | Active-low port select |
| hostStrobeN | input | 1 | Active-low access strobe |
| hostRnW | input | 1 | 1 = host read, 0 = host write |
| hostRegSel | input | 2 | Register select (see encoding) |
| hostHalf | input | 1 | Halfword select in 16-bit mode |
| hostReady | output | 1 | High when the port can take or finish an access |
| hostIntN | output | 1 | Active-low interrupt to the host |
| cpuCtlWe | input | 1 | CPU write strobe for the control flags |
| cpuCtlWdata | input | 2 | Bit 0 clears host-to-CPU flag, bit 1 sets CPU-to-host flag |
| cpuCtlRdata | output | DW | Control register as seen by the CPU |
| cpuInt | output | 1 | Interrupt to the CPU |
| memReq | output | 1 | Internal single-beat request |
| memWe | output | 1 | Internal request is a write |
| memAddr | output | AW | Internal word address |
| memWdata | output | DW | Internal write data |
| memRdata | input | DW | Internal read data, valid with memAck |
| memAck | input | 1 | Internal access acknowledge |

## Verification
Suppose the address register picks up a wrong value or misses an increment. The first internal access after that lands on the wrong `memAddr`, which shows in the bench's memory image within the same host access. A half-loaded data lane shows as a wrong assembled word at the internal write. A stuck wait state shows as ready never rising or as an extra internal access, seen within a few clocks of the strobe. Flag errors show at `cpuInt` and `hostIntN`, which are compared against a behavioural model on every clock.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_ADDR     = 2'b01,
    SEL_DATA_INC = 2'b10,
    SEL_DATA_FIX = 2'b11
  } regSel_e;

  typedef enum logic { ST_IDLE = 1'b0, ST_WAIT = 1'b1 } portState_e;

  typedef struct packed {
    logic ldAddr;
    logic ldData;
    logic ctlWr;
    logic capRead;
    logic incAddr;
  } dpStrobe_t;

  localparam int CTL_WIDE = 0;
  localparam int CTL_H2C  = 1;
  localparam int CTL_C2H  = 2;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic activeRaw,
  output logic startPulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], activeRaw};
  end

  assign startPulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl import hmp_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      wideMode,
  input  logic      hostRnW,
  input  logic      hostHalf,
  input  logic [1:0] hostRegSel,
  input  logic      memAck,
  output dpStrobe_t strb,
  output logic      memReq,
  output logic      memWe,
  output logic      hostReady
);
  portState_e state;
  logic weQ;
  logic incQ;
  logic isData;
  logic startsMem;

  assign isData    = hostRegSel[1];
  assign startsMem = isData && (hostRnW ? (wideMode || !hostHalf)
                                        : (wideMode ||  hostHalf));

  always_comb begin
    strb = '0;
    if (state == ST_IDLE && startPulse) begin
      strb.ldAddr = (hostRegSel == SEL_ADDR) && !hostRnW;
      strb.ldData = isData && !hostRnW;
      strb.ctlWr  = (hostRegSel == SEL_CTRL) && !hostRnW;
    end
    if (state == ST_WAIT && memAck) begin
      strb.capRead = !weQ;
      strb.incAddr = incQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      weQ   <= 1'b0;
      incQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startPulse && startsMem) begin
          state <= ST_WAIT;
          weQ   <= !hostRnW;
          incQ  <= (hostRegSel == SEL_DATA_INC);
        end
        ST_WAIT: if (memAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq    = (state == ST_WAIT);
  assign memWe     = weQ;
  assign hostReady = (state == ST_IDLE);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);

  p_start_sync_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(startPulse));
endmodule

// File: rtl/hmp_datapath.sv
module hmp_datapath import hmp_pkg::*; #(
  parameter int DW = 32,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          widthStrap,
  input  dpStrobe_t     strb,
  input  logic [DW-1:0] busIn,
  input  logic [1:0]    hostRegSel,
  input  logic          hostHalf,
  input  logic [DW-1:0] memRdata,
  input  logic          cpuCtlWe,
  input  logic [1:0]    cpuCtlWdata,
  output logic          wideMode,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] busOut,
  output logic [DW-1:0] ctrlWord,
  output logic          hostToCpu,
  output logic          cpuToHost
);
  localparam int HW    = DW / 2;
  localparam int LANES = 2;

  logic [DW-1:0] addrReg;
  logic [DW-1:0] dataReg;
  logic [DW-1:0] addrMerge;
  logic [DW-1:0] dataMerge;
  logic [DW-1:0] regVal;
  logic [LANES-1:0] laneHit;
  logic hostCtlWr;

  always_ff @(posedge clk) begin
    if (!rstN) wideMode <= widthStrap;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [HW-1:0] laneSrc;
    assign laneHit[g] = wideMode | (hostHalf == 1'(g));
    assign laneSrc    = wideMode ? busIn[g*HW +: HW] : busIn[HW-1:0];
    assign addrMerge[g*HW +: HW] = laneHit[g] ? laneSrc : addrReg[g*HW +: HW];
    assign dataMerge[g*HW +: HW] = laneHit[g] ? laneSrc : dataReg[g*HW +: HW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strb.ldAddr)       addrReg <= addrMerge;
      else if (strb.incAddr) addrReg <= addrReg + 1'b1;
      if (strb.ldData)       dataReg <= dataMerge;
      else if (strb.capRead) dataReg <= memRdata;
    end
  end

  assign hostCtlWr = strb.ctlWr && laneHit[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostToCpu <= 1'b0;
      cpuToHost <= 1'b0;
    end else begin
      if (hostCtlWr && busIn[CTL_H2C])          hostToCpu <= 1'b1;
      else if (cpuCtlWe && cpuCtlWdata[0])      hostToCpu <= 1'b0;
      if (cpuCtlWe && cpuCtlWdata[1])           cpuToHost <= 1'b1;
      else if (hostCtlWr && busIn[CTL_C2H])     cpuToHost <= 1'b0;
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CTL_WIDE] = wideMode;
    ctrlWord[CTL_H2C]  = hostToCpu;
    ctrlWord[CTL_C2H]  = cpuToHost;
  end

  always_comb begin
    case (hostRegSel)
      SEL_CTRL: regVal = ctrlWord;
      SEL_ADDR: regVal = addrReg;
      default:  regVal = dataReg;
    endcase
    if (wideMode)      busOut = regVal;
    else if (hostHalf) busOut = {{(DW-HW){1'b0}}, regVal[DW-1:HW]};
    else               busOut = {{(DW-HW){1'b0}}, regVal[HW-1:0]};
  end

  assign memAddr  = addrReg[AW-1:0];
  assign memWdata = dataReg;

  p_strap_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> $stable(wideMode));

  p_h2c_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlWr && laneHit[0] && busIn[CTL_H2C] |=> hostToCpu);
endmodule

// File: rtl/host_mux_port.sv
module host_mux_port import hmp_pkg::*; #(
  parameter int DW = 32,
  parameter int AW = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          widthStrap,
  input  logic [DW-1:0] hostBusIn,
  output logic [DW-1:0] hostBusOut,
  output logic          hostBusOe,
  input  logic          hostSelN,
  input  logic          hostStrobeN,
  input  logic          hostRnW,
  input  logic [1:0]    hostRegSel,
  input  logic          hostHalf,
  output logic          hostReady,
  output logic          hostIntN,
  input  logic          cpuCtlWe,
  input  logic [1:0]    cpuCtlWdata,
  output logic [DW-1:0] cpuCtlRdata,
  output logic          cpuInt,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memAck
);
  dpStrobe_t strb;
  logic startPulse;
  logic wideMode;
  logic hostToCpu;
  logic cpuToHost;

  hmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .activeRaw(~(hostSelN | hostStrobeN)),
    .startPulse(startPulse)
  );

  hmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .wideMode(wideMode),
    .hostRnW(hostRnW), .hostHalf(hostHalf), .hostRegSel(hostRegSel),
    .memAck(memAck), .strb(strb), .memReq(memReq), .memWe(memWe),
    .hostReady(hostReady)
  );

  hmp_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .widthStrap(widthStrap), .strb(strb),
    .busIn(hostBusIn), .hostRegSel(hostRegSel), .hostHalf(hostHalf),
    .memRdata(memRdata), .cpuCtlWe(cpuCtlWe), .cpuCtlWdata(cpuCtlWdata),
    .wideMode(wideMode), .memAddr(memAddr), .memWdata(memWdata),
    .busOut(hostBusOut), .ctrlWord(cpuCtlRdata),
    .hostToCpu(hostToCpu), .cpuToHost(cpuToHost)
  );

  assign hostBusOe = ~hostSelN & ~hostStrobeN & hostRnW;
  assign cpuInt    = hostToCpu;
  assign hostIntN  = ~cpuToHost;

  p_req_payload_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata));
endmodule

// File: tb/sim_host_mux_port.sv
`timescale 1ns/1ps
module sim_host_mux_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        widthStrap = 1'b1;
  logic [31:0] hostBusIn = '0;
  logic [31:0] hostBusOut;
  logic        hostBusOe;
  logic        hostSelN = 1'b1;
  logic        hostStrobeN = 1'b1;
  logic        hostRnW = 1'b1;
  logic [1:0]  hostRegSel = 2'b00;
  logic        hostHalf = 1'b0;
  logic        hostReady;
  logic        hostIntN;
  logic        cpuCtlWe = 1'b0;
  logic [1:0]  cpuCtlWdata = '0;
  logic [31:0] cpuCtlRdata;
  logic        cpuInt;
  logic        memReq;
  logic        memWe;
  logic [19:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  host_mux_port u0 (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit settle = 0;
  bit modelH2C = 0;
  bit modelC2H = 0;
  int ackDelay = 0;
  int waitCnt = 0;
  int accesses = 0;
  logic [31:0] mem [int];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural memory responder
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (waitCnt >= ackDelay) begin
        if (memWe) mem[int'(memAddr)] = memWdata;
        else memRdata = mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 32'hDEAD0000 ^ 32'(memAddr);
        memAck = 1'b1;
        waitCnt = 0;
        accesses++;
      end else waitCnt++;
    end
  end

  // per-clock comparison of the doorbell outputs against the model
  always @(negedge clk) begin
    if (rstN && settle && !done) begin
      chk(cpuInt == modelH2C, "R10 cpuInt", 32'(cpuInt), 32'(modelH2C));
      chk(hostIntN == !modelC2H, "R11 hostIntN", 32'(hostIntN), 32'(!modelC2H));
    end
  end

  task automatic doReset(input bit strap);
    settle = 0;
    rstN = 1'b0;
    widthStrap = strap;
    repeat (3) @(negedge clk);
    chk(hostReady && hostIntN && !cpuInt && !memReq, "R1 reset",
        {28'd0, hostReady, hostIntN, cpuInt, memReq}, 32'hC);
    rstN = 1'b1;
    modelH2C = 0; modelC2H = 0;
    @(negedge clk);
    chk(hostReady && hostIntN && !cpuInt && !memReq, "R1 after reset",
        {28'd0, hostReady, hostIntN, cpuInt, memReq}, 32'hC);
    settle = 1;
  endtask

  task automatic hostOp(input bit rnw, input logic [1:0] sel, input bit half,
                        input logic [31:0] wd, output logic [31:0] rd, output int low);
    low = 0;
    @(negedge clk);
    if (!rnw && sel == 2'b00) settle = 0;
    hostRnW = rnw; hostRegSel = sel; hostHalf = half; hostBusIn = wd;
    hostSelN = 1'b0; hostStrobeN = 1'b0;
    repeat (4) begin @(negedge clk); if (!hostReady) low++; end
    while (!hostReady) begin @(negedge clk); low++; end
    rd = hostBusOut;
    hostStrobeN = 1'b1; hostSelN = 1'b1;
    repeat (3) @(negedge clk);
    if (!rnw && sel == 2'b00) begin
      if (wd[1]) modelH2C = 1;
      if (wd[2]) modelC2H = 0;
      settle = 1;
    end
  endtask

  task automatic cpuWrite(input logic [1:0] d);
    @(negedge clk);
    settle = 0;
    cpuCtlWe = 1'b1; cpuCtlWdata = d;
    @(negedge clk);
    cpuCtlWe = 1'b0; cpuCtlWdata = '0;
    if (d[0]) modelH2C = 0;
    if (d[1]) modelC2H = 1;
    settle = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int low;
    int acc0;
    // ---------------- 32-bit mode ----------------
    doReset(1'b1);
    hostOp(1, 2'b00, 0, 0, rd, low);
    chk(rd == 32'h1, "R2 strap wide", rd, 32'h1);
    chk(low == 0, "R3 ctrl read ready", low, 0);
    hostOp(0, 2'b01, 0, 32'h100, rd, low);
    hostOp(1, 2'b01, 0, 0, rd, low);
    chk(rd == 32'h100, "R3 addr readback", rd, 32'h100);
    chk(low == 0 && accesses == 0, "R3 no access", accesses, 0);
    for (int i = 0; i < 3; i++) begin
      ackDelay = i * 3;
      acc0 = accesses;
      hostOp(0, 2'b10, 0, 32'hA0B0C000 + i, rd, low);
      chk(accesses == acc0 + 1, "R12 one access per strobe", accesses, acc0 + 1);
      chk(low > 0, "R5 ready low on write", low, 1);
      chk(mem.exists(32'h100 + i) && mem[32'h100 + i] == 32'hA0B0C000 + i, "R4 write word",
          mem.exists(32'h100 + i) ? mem[32'h100 + i] : 32'hX, 32'hA0B0C000 + i);
    end
    hostOp(1, 2'b01, 0, 0, rd, low);
    chk(rd == 32'h103, "R7 autoincrement", rd, 32'h103);
    hostOp(0, 2'b11, 0, 32'h5555AAAA, rd, low);
    chk(mem[32'h103] == 32'h5555AAAA, "R4 fixed write", mem[32'h103], 32'h5555AAAA);
    hostOp(1, 2'b01, 0, 0, rd, low);
    chk(rd == 32'h103, "R7 no increment", rd, 32'h103);
    // reads
    mem[32'h200] = 32'h13572468;
    mem[32'h201] = 32'h89ABCDEF;
    hostOp(0, 2'b01, 0, 32'h200, rd, low);
    ackDelay = 20;
    hostOp(1, 2'b10, 0, 0, rd, low);
    chk(rd == 32'h13572468, "R6 read data", rd, 32'h13572468);
    chk(low >= 20, "R5 ready held for slow ack", low, 20);
    ackDelay = 1;
    hostOp(1, 2'b11, 0, 0, rd, low);
    chk(rd == 32'h89ABCDEF, "R6 read second", rd, 32'h89ABCDEF);
    hostOp(1, 2'b01, 0, 0, rd, low);
    chk(rd == 32'h201, "R7 read address", rd, 32'h201);
    // doorbells
    hostOp(0, 2'b00, 0, 32'h2, rd, low);
    chk(cpuInt == 1'b1, "R10 host sets", cpuInt, 1);
    chk(cpuCtlRdata == 32'h3, "R10 cpu view", cpuCtlRdata, 32'h3);
    cpuWrite(2'b01);
    chk(cpuInt == 1'b0, "R10 cpu clears", cpuInt, 0);
    cpuWrite(2'b10);
    chk(hostIntN == 1'b0, "R11 cpu sets", hostIntN, 0);
    hostOp(1, 2'b00, 0, 0, rd, low);
    chk(rd == 32'h5, "R11 host view", rd, 32'h5);
    hostOp(0, 2'b00, 0, 32'h4, rd, low);
    chk(hostIntN == 1'b1, "R11 host clears", hostIntN, 1);
    // ---------------- 16-bit mode ----------------
    doReset(1'b0);
    hostOp(1, 2'b00, 0, 0, rd, low);
    chk(rd == 32'h0, "R2 strap narrow", rd, 0);
    hostOp(0, 2'b01, 0, 32'hFFFF0010, rd, low);
    hostOp(0, 2'b01, 1, 32'h00000002, rd, low);
    hostOp(1, 2'b01, 0, 0, rd, low);
    chk(rd == 32'h0010, "R8 addr low half", rd, 32'h0010);
    hostOp(1, 2'b01, 1, 0, rd, low);
    chk(rd == 32'h0002, "R8 addr high half", rd, 32'h0002);
    acc0 = accesses;
    hostOp(0, 2'b10, 0, 32'h0000BEEF, rd, low);
    chk(accesses == acc0 && low == 0, "R8 low half no access", accesses, acc0);
    hostOp(0, 2'b10, 1, 32'h0000CAFE, rd, low);
    chk(mem.exists(32'h20010) && mem[32'h20010] == 32'hCAFEBEEF, "R8 assembled write",
        mem.exists(32'h20010) ? mem[32'h20010] : 32'hX, 32'hCAFEBEEF);
    mem[32'h20011] = 32'h12345678;
    acc0 = accesses;
    hostOp(1, 2'b10, 0, 0, rd, low);
    chk(rd == 32'h00005678, "R9 read low half", rd, 32'h00005678);
    chk(accesses == acc0 + 1, "R9 low half access", accesses, acc0 + 1);
    hostOp(1, 2'b10, 1, 0, rd, low);
    chk(rd == 32'h00001234, "R9 read high half", rd, 32'h00001234);
    chk(accesses == acc0 + 1 && low == 0, "R9 high half no access", accesses, acc0 + 1);
    hostOp(1, 2'b01, 0, 0, rd, low);
    chk(rd == 32'h0012, "R7 narrow increment", rd, 32'h0012);
    widthStrap = 1'b1;
    repeat (4) @(negedge clk);
    hostOp(1, 2'b00, 0, 0, rd, low);
    chk(rd == 32'h0, "R2 strap ignored after reset", rd, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule